// File: doc/BRIEF.md
# Receive Word FIFO with Programmable Level Flags

This block buffers 32-bit words arriving from a parallel digital input link until a consumer, typically a DMA engine, drains them. Incoming words are accepted only while reception is enabled. The consumer sees the oldest stored word at all times on its read port, and a data-ready output tells it when at least one word is waiting.

The FIFO reports its fill state through four active-high "not" flags: not empty, not almost empty, not almost full and not full. Two programmable thresholds, packed into one register, set where the almost flags switch. Writing while full is an overrun, and reading while empty is an underrun. Each of these errors sets a sticky bit that software clears by writing 1 to that bit. A control register holds the receive enable and a self-clearing flush bit. The capacity and the live word count can also be read. After reset, a settling window holds off all FIFO traffic. Its length is a parameter, set by default to 10 us at 100 MHz.

Register port (word index on `reg_addr`): 0 control, 1 thresholds, 2 status, 3 capacity, 4 word count. Reads are combinational. Writes take effect at the clock edge.

Top module: `rx_word_fifo`

## Requirements
- R1: After reset the word count reads 0, status reads 0x0000C000, capacity reads DEPTH, and the threshold register reads AF_RESET in bits 23:16 and AE_RESET in bits 15:0.
- R2: For the first SETTLE_CYCLES clocks after reset, pushes and pops are ignored: the count stays 0 and no error bit is set.
- R3: A push is stored only while control bit 1 (receive enable) is 1. Otherwise the word is dropped and the count does not change.
- R4: Words leave in arrival order on pop_data. A push and a pop in the same cycle leave the count unchanged.
- R5: Status bit 12 is count != 0, bit 13 is count > almost-empty threshold, bit 14 is (DEPTH - count) > almost-full threshold, and bit 15 is count != DEPTH.
- R6: Threshold register bits 15:0 hold the almost-empty count and bits 23:16 hold the almost-full count. Both read back as written.
- R7: A push while enabled and full sets status bit 23 (overrun) and drops the word. The bit stays set afterwards.
- R8: A pop while empty sets status bit 22 (underrun) and changes nothing else.
- R9: Writing 1 to status bit 22 or 23 clears that bit. Writing 0 leaves it set. If a new error and a clear fall in the same cycle, the error wins.
- R10: Writing 1 to control bit 0 empties the FIFO in one cycle. The bit reads back as 0.
- R11: data_ready equals the not-empty flag at all times.
- R12: Capacity and word count read as 20-bit values in bits 19:0, with upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Incoming word valid |
| push_data | input | 32 | Incoming word |
| pop | input | 1 | Consumer takes the head word |
| pop_data | output | 32 | Head word |
| data_ready | output | 1 | At least one word stored |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The bench drives the FIFO to exactly full and exactly empty and then pushes or pops once more. A design that mis-sized the full test would wrap and corrupt the head word, or would miss the sticky error bit. It walks the thresholds one word at a time, so an off-by-one in the comparisons would switch the almost flags a word early or late. It also tries traffic during the settling window and with reception disabled, and it writes 0 to set error bits. A design that leaked a word through either gate, or cleared on any write, would show a non-zero count or a lost error bit.

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
  parameter int DEPTH         = 64,
  parameter int SETTLE_CYCLES = 1000,
  parameter int AE_RESET      = 16,
  parameter int AF_RESET      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [31:0] push_data,
  input  logic        pop,
  output logic [31:0] pop_data,
  output logic        data_ready,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_THR = 3'd1, A_STAT = 3'd2,
                         A_CAP = 3'd3, A_LVL = 3'd4;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level;
  logic [SW-1:0] settle_cnt;
  logic          rx_en, ovr, udr;
  logic [15:0]   ae_th;
  logic [7:0]    af_th;

  wire settled = settle_cnt == SW'(SETTLE_CYCLES);
  wire empty   = level == '0;
  wire full    = level == CW'(DEPTH);
  wire flush   = reg_wr && reg_addr == A_CTRL && reg_wdata[0];
  wire do_push = push && rx_en && settled && !full && !flush;
  wire do_pop  = pop && settled && !empty && !flush;
  wire ovr_set = push && rx_en && settled && full;
  wire udr_set = pop && settled && empty;
  wire st_wr   = reg_wr && reg_addr == A_STAT;

  wire f_ne  = !empty;
  wire f_nae = 32'(level) > 32'(ae_th);
  wire f_naf = (32'(DEPTH) - 32'(level)) > 32'(af_th);
  wire f_nf  = !full;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) settle_cnt <= '0;
    else if (!settled) settle_cnt <= settle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
      ae_th <= 16'(AE_RESET);
      af_th <= 8'(AF_RESET);
      ovr   <= 1'b0;
      udr   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) rx_en <= reg_wdata[1];
      if (reg_wr && reg_addr == A_THR) begin
        ae_th <= reg_wdata[15:0];
        af_th <= reg_wdata[23:16];
      end
      if (ovr_set)                  ovr <= 1'b1;
      else if (st_wr && reg_wdata[23]) ovr <= 1'b0;
      if (udr_set)                  udr <= 1'b1;
      else if (st_wr && reg_wdata[22]) udr <= 1'b0;
    end
  end

  assign pop_data   = mem[rd_ptr];
  assign data_ready = f_ne;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {30'b0, rx_en, 1'b0};
      A_THR:   reg_rdata = {8'b0, af_th, ae_th};
      A_STAT:  reg_rdata = {8'b0, ovr, udr, 6'b0, f_nf, f_naf, f_nae, f_ne, 12'b0};
      A_CAP:   reg_rdata = {12'b0, 20'(DEPTH)};
      A_LVL:   reg_rdata = {12'b0, 20'(level)};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rx_word_fifo_chk.sv
module rx_word_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          pop,
  input logic          rx_en,
  input logic          settled,
  input logic [CW-1:0] level,
  input logic          ovr,
  input logic          udr,
  input logic          data_ready
);
  a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);
  a_r11_ready_matches: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready == (level != '0));
  a_r2_settle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !settled |=> level == '0);
  a_r3_disabled_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !rx_en) |=> level <= $past(level));
  a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (push && rx_en && settled && 32'(level) == DEPTH) |=> ovr);
  a_r8_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && settled && level == '0) |=> udr);
endmodule

bind rx_word_fifo rx_word_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .rx_en(rx_en),
  .settled(settled), .level(level), .ovr(ovr), .udr(udr),
  .data_ready(data_ready)
);

// File: tb/test_rx_word_fifo.sv
module test_rx_word_fifo;
  localparam int DEPTH = 64;
  localparam int SETTLE = 1000;

  logic        clk = 0, rst_n = 0, push = 0, pop = 0, reg_wr = 0;
  logic [31:0] push_data = 0, reg_wdata = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] pop_data, reg_rdata;
  logic        data_ready;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_word_fifo i_rx_word_fifo (.*);

  // {push, pop, data, expected head before op, expected level, flags {nf,naf,nae,ne}}
  localparam logic [77:0] VEC [6] = '{
    {1'b1, 1'b0, 32'hA000_0001, 32'h0,         8'd1, 4'b1101},
    {1'b1, 1'b0, 32'hB000_0002, 32'h0,         8'd2, 4'b1111},
    {1'b0, 1'b1, 32'h0,         32'hA000_0001, 8'd1, 4'b1101},
    {1'b1, 1'b1, 32'hC000_0003, 32'hB000_0002, 8'd1, 4'b1101},
    {1'b0, 1'b1, 32'h0,         32'hC000_0003, 8'd0, 4'b1100},
    {1'b1, 1'b0, 32'hD000_0004, 32'h0,         8'd1, 4'b1101}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic step(input logic pu, input logic po, input logic [31:0] d);
    push = pu; pop = po; push_data = d;
    @(negedge clk);
    push = 0; pop = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd4, v); chk("R1 level", v, 0);
    rd(3'd2, v); chk("R1 status", v, 32'h0000C000);
    rd(3'd3, v); chk("R1/R12 capacity", v, DEPTH);
    rd(3'd1, v); chk("R1 thresholds", v, 32'h0010_0010);
    // R2: traffic during settling window
    wr(3'd0, 32'h2);
    step(1, 0, 32'h1234);
    step(0, 1, 0);
    rd(3'd4, v); chk("R2 level during settle", v, 0);
    rd(3'd2, v); chk("R2 no error during settle", v, 32'h0000C000);
    repeat (SETTLE + 5) @(negedge clk);
    // R6 thresholds
    wr(3'd1, 32'h0001_0001);
    rd(3'd1, v); chk("R6 threshold readback", v, 32'h0001_0001);
    // table: R4, R5, R11
    for (int i = 0; i < 6; i++) begin
      if (VEC[i][76]) begin
        v = pop_data; chk("R4 head order", v, VEC[i][43:12]);
      end
      step(VEC[i][77], VEC[i][76], VEC[i][75:44]);
      rd(3'd4, v); chk("R4 level", v, 32'(VEC[i][11:4]));
      rd(3'd2, v); chk("R5 flags", 32'(v[15:12]), 32'(VEC[i][3:0]));
      chk("R11 data_ready", 32'(data_ready), 32'(VEC[i][0]));
    end
    // R10 flush
    wr(3'd0, 32'h3);
    rd(3'd4, v); chk("R10 flush empties", v, 0);
    rd(3'd0, v); chk("R10 flush bit reads 0", v, 32'h2);
    chk("R11 ready after flush", 32'(data_ready), 0);
    // R3 disabled push ignored
    wr(3'd0, 32'h0);
    step(1, 0, 32'hDEAD);
    rd(3'd4, v); chk("R3 disabled push dropped", v, 0);
    wr(3'd0, 32'h2);
    // fill to full
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 0, 32'h100 + i);
      if (i == DEPTH - 3) begin rd(3'd2, v); chk("R5 naf at 62", 32'(v[14]), 1); end
      if (i == DEPTH - 2) begin rd(3'd2, v); chk("R5 naf at 63", 32'(v[14]), 0); end
    end
    rd(3'd2, v); chk("R5 full flags", v, 32'h00003000);
    // R7 overrun
    step(1, 0, 32'hBAD0);
    rd(3'd4, v); chk("R7 level held", v, DEPTH);
    rd(3'd2, v); chk("R7 overrun set", 32'(v[23]), 1);
    v = pop_data; chk("R7 head intact", v, 32'h100);
    repeat (2) @(negedge clk);
    rd(3'd2, v); chk("R7 overrun sticky", 32'(v[23]), 1);
    wr(3'd2, 32'h0);
    rd(3'd2, v); chk("R9 write 0 keeps", 32'(v[23]), 1);
    wr(3'd2, 32'h0080_0000);
    rd(3'd2, v); chk("R9 write 1 clears", 32'(v[23]), 0);
    // drain, then R8 underrun
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) begin v = pop_data; chk("R4 last word", v, 32'h100 + DEPTH - 1); end
      step(0, 1, 0);
    end
    rd(3'd2, v); chk("R5 empty flags", v, 32'h0000C000);
    step(0, 1, 0);
    rd(3'd2, v); chk("R8 underrun set", v, 32'h0040C000);
    rd(3'd4, v); chk("R8 level unchanged", v, 0);
    wr(3'd2, 32'h0040_0000);
    rd(3'd2, v); chk("R9 underrun cleared", v, 32'h0000C000);
    finish_run();
  end
endmodule